// File: doc/BRIEF.md
# Mailbox Responder Register Interface

This block is the device-side endpoint of a request/response mailbox. Software addresses four dword registers: control, status, write-data and read-data. It builds a request object one dword at a time through the write-data register and then sets the start bit in the control register. The block checks that the number of dwords it received equals the length given in the object header. If the count matches, it streams the request to a protocol handler over a valid/ready port. It then collects the handler's reply into a response FIFO, and software drains that FIFO through the read-data register.

An object consists of two header dwords followed by the payload. Bits [17:0] of the second header dword hold the total object length in dwords, and that count includes both header dwords. A length field of zero stands for 2^18 dwords. Reading read-data returns the head dword of the response and has no side effect. Writing any value to read-data discards that dword and moves to the next one. The abort bit returns the whole exchange to its idle state.

Register map (reg_addr): 0 = control, 1 = status, 2 = write-data, 3 = read-data. Control bits: bit 0 = abort, bit 1 = start. Abort takes priority when both are written together. Status bits: bit 0 = busy, bit 1 = error, bit 2 = response ready. All other bits read as zero, and the control and write-data registers read as zero.

Top module: `mbox_responder`

## Requirements
- R1: After reset the status register reads 0 and the read-data register reads 0.
- R2: A start write (control bit 1) accepted with a matching length sets busy and sends the buffered dwords to the handler in the order they were written, with hreq_last on the final one. The length is taken from bits [17:0] of the second dword; zero means 2^18.
- R3: Busy stays 1 until the handler's response dword marked hrsp_last is accepted. Busy then clears and response ready (status bit 2) sets in the same cycle.
- R4: While response ready is 1, read-data returns the head response dword and reading it does not advance. Each write to read-data advances by one dword. Response ready clears when the last dword is popped.
- R5: When response ready is 0, read-data reads 0 and a write to it changes nothing.
- R6: A start write whose buffered dword count differs from the header length (or is below 2) sets error, leaves busy at 0, produces no response and discards the buffered request.
- R7: A write-data access while the request FIFO already holds DEPTH dwords sets error and the dword is dropped.
- R8: A write-data access or a start write while busy sets error.
- R9: An abort write clears busy, error and response ready on the next cycle and empties both FIFOs.
- R10: A start write while error is 1 is ignored: busy stays 0 and no request reaches the handler.
- R11: Response dwords offered by the handler while the response FIFO is full are dropped and set error. The stored dwords remain readable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| hreq_valid | output | 1 | Request dword valid toward handler |
| hreq_data | output | 32 | Request dword |
| hreq_last | output | 1 | Final request dword |
| hreq_ready | input | 1 | Handler accepts request dword |
| hrsp_valid | input | 1 | Response dword valid from handler |
| hrsp_data | input | 32 | Response dword |
| hrsp_last | input | 1 | Final response dword |
| hrsp_ready | output | 1 | Block accepts response dword |

## Verification
The assertions assume that the handler sends a response only after it has taken the whole request, and that it always finishes its response with hrsp_last. The testbench supplies a loopback handler that meets both conditions. It echoes the captured request back and can hold its answer or append extra dwords, which gives a controlled busy window and a controlled overflow. Software-side stimulus never aborts while the handler is midway through its reply, because a held handler would then keep offering dwords that the block no longer expects.

// File: rtl/mbox_responder.sv
module mbox_responder #(
  parameter int DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        hreq_valid,
  output logic [31:0] hreq_data,
  output logic        hreq_last,
  input  logic        hreq_ready,
  input  logic        hrsp_valid,
  input  logic [31:0] hrsp_data,
  input  logic        hrsp_last,
  output logic        hrsp_ready
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [AW-1:0] LASTP = AW'(DEPTH - 1);

  typedef enum logic [1:0] {S_IDLE, S_SEND, S_WAIT} st_t;
  st_t st;

  logic [31:0] qmem [DEPTH];
  logic [31:0] pmem [DEPTH];
  logic [AW-1:0] q_wp, q_rp, p_wp, p_rp;
  logic [CW-1:0] q_cnt, p_cnt;
  logic [17:0] hdr_len;
  logic busy, err, rdy;

  wire wr_ctl  = reg_wr && reg_addr == 2'd0;
  wire abort   = wr_ctl && reg_wdata[0];
  wire go      = wr_ctl && reg_wdata[1] && !reg_wdata[0];
  wire wr_dat  = reg_wr && reg_addr == 2'd2;
  wire wr_pop  = reg_wr && reg_addr == 2'd3;

  wire [18:0] exp_len = (hdr_len == 18'd0) ? 19'h40000 : {1'b0, hdr_len};
  wire len_ok    = (32'(q_cnt) == 32'(exp_len)) && (q_cnt >= CW'(2));
  wire go_ok     = go && !busy && !err;
  wire q_push    = wr_dat && !busy && q_cnt != FULL;
  wire q_pop     = st == S_SEND && hreq_ready;
  wire q_flush   = abort || (go_ok && !len_ok);
  wire p_push    = st == S_WAIT && hrsp_valid && p_cnt != FULL;
  wire p_pop     = wr_pop && rdy;
  wire p_flush   = abort || go_ok;

  assign hreq_valid = st == S_SEND;
  assign hreq_data  = qmem[q_rp];
  assign hreq_last  = q_cnt == CW'(1);
  assign hrsp_ready = st == S_WAIT;

  always_comb begin
    case (reg_addr)
      2'd1:    reg_rdata = {29'd0, rdy, err, busy};
      2'd3:    reg_rdata = rdy ? pmem[p_rp] : 32'd0;
      default: reg_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (q_push) qmem[q_wp] <= reg_wdata;
    if (p_push) pmem[p_wp] <= hrsp_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || q_flush) begin
      q_wp <= '0; q_rp <= '0; q_cnt <= '0;
    end else begin
      if (q_push) begin
        q_wp <= (q_wp == LASTP) ? '0 : q_wp + 1'b1;
        if (q_cnt == CW'(1)) hdr_len <= reg_wdata[17:0];
      end
      if (q_pop) q_rp <= (q_rp == LASTP) ? '0 : q_rp + 1'b1;
      q_cnt <= q_cnt + CW'(q_push) - CW'(q_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || p_flush) begin
      p_wp <= '0; p_rp <= '0; p_cnt <= '0;
    end else begin
      if (p_push) p_wp <= (p_wp == LASTP) ? '0 : p_wp + 1'b1;
      if (p_pop)  p_rp <= (p_rp == LASTP) ? '0 : p_rp + 1'b1;
      p_cnt <= p_cnt + CW'(p_push) - CW'(p_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || abort) begin
      st <= S_IDLE; busy <= 1'b0; err <= 1'b0; rdy <= 1'b0;
    end else begin
      if ((wr_dat && (busy || q_cnt == FULL)) || (go && busy) ||
          (go_ok && !len_ok) ||
          (st == S_WAIT && hrsp_valid && p_cnt == FULL))
        err <= 1'b1;
      if (go_ok) begin
        rdy <= 1'b0;
        if (len_ok) begin
          busy <= 1'b1;
          st   <= S_SEND;
        end
      end
      if (q_pop && q_cnt == CW'(1)) st <= S_WAIT;
      if (st == S_WAIT && hrsp_valid && hrsp_last) begin
        st   <= S_IDLE;
        busy <= 1'b0;
        rdy  <= (p_cnt != '0) || p_push;
      end
      if (p_pop && p_cnt == CW'(1)) rdy <= 1'b0;
    end
  end

  p_ready_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rdy |-> !busy);
  p_ready_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rdy |-> p_cnt != '0);
  p_busy_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(reg_wr && reg_addr == 2'd0 && reg_wdata[1]));
  p_send_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hreq_valid |-> busy);
  p_mismatch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (go_ok && !len_ok && !abort) |=> (err && !busy && q_cnt == '0));
  p_abort_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!busy && !err && !rdy && q_cnt == '0 && p_cnt == '0));
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    q_cnt <= FULL && p_cnt <= FULL);
endmodule

// File: tb/sim_mbox_responder.sv
module sim_mbox_responder;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0;
  logic [1:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic hreq_valid, hreq_last, hrsp_ready;
  logic [31:0] hreq_data;
  logic hreq_ready = 1;
  logic hrsp_valid = 0, hrsp_last = 0;
  logic [31:0] hrsp_data = 0;

  int checks = 0, errors = 0;

  mbox_responder #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .hreq_valid(hreq_valid), .hreq_data(hreq_data), .hreq_last(hreq_last),
    .hreq_ready(hreq_ready), .hrsp_valid(hrsp_valid), .hrsp_data(hrsp_data),
    .hrsp_last(hrsp_last), .hrsp_ready(hrsp_ready));

  always #(CLK_PERIOD/2) clk = ~clk;

  // loopback handler
  logic [31:0] cap [64];
  int cap_n = 0, got_n = 0, last_pos = -1, ridx = 0, extra = 0;
  bit emit = 0, hold = 0, acc_pend = 0;

  always @(negedge clk) begin
    if (acc_pend) ridx++;
    acc_pend = 0;
    if (emit && ridx >= cap_n + extra) begin emit = 0; cap_n = 0; end
    if (hreq_valid && hreq_ready) begin
      cap[cap_n] = hreq_data;
      if (hreq_last) begin last_pos = cap_n; got_n = cap_n + 1; emit = 1; ridx = 0; end
      cap_n++;
    end
    if (emit && !hold && ridx < got_n + extra) begin
      hrsp_valid = 1;
      hrsp_data  = (ridx < got_n) ? cap[ridx] : 32'hEE00_0000 + ridx;
      hrsp_last  = (ridx == got_n + extra - 1);
      acc_pend   = hrsp_ready;
    end else begin
      hrsp_valid = 0; hrsp_last = 0;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    reg_addr = a; reg_wr = 0;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int k = 0; k < 200; k++) begin
      rd(2'd1, s);
      if (!s[0]) break;
      @(negedge clk);
    end
  endtask

  function automatic logic [31:0] pword(int n, int i);
    if (i == 0) return 32'hA500_0000 | n;
    if (i == 1) return n + 2;
    return n * 256 + i * 3 + 7;
  endfunction

  task automatic send_obj(int n);
    for (int i = 0; i < n + 2; i++) wr(2'd2, pword(n, i));
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    rd(2'd1, v); check("R1 status", v, 0);
    rd(2'd3, v); check("R1 rdata", v, 0);

    // sweep all legal lengths
    for (int n = 0; n <= DEPTH - 2; n++) begin
      send_obj(n);
      wr(2'd0, 32'h2);
      rd(2'd1, v); check("R2 busy after start", v[0], 1);
      wait_idle();
      rd(2'd1, v); check("R3 ready no busy", v, 32'h4);
      check("R2 handler count", got_n, n + 2);
      check("R2 last position", last_pos, n + 1);
      for (int i = 0; i < n + 2; i++) check("R2 handler order", cap[i], pword(n, i));
      for (int i = 0; i < n + 2; i++) begin
        rd(2'd3, v); check("R4 head dword", v, pword(n, i));
        @(negedge clk);
        rd(2'd3, v); check("R4 read no pop", v, pword(n, i));
        rd(2'd1, v); check("R4 ready held", v[2], 1);
        wr(2'd3, 0);
      end
      rd(2'd1, v); check("R4 ready cleared", v, 0);
      rd(2'd3, v); check("R5 empty reads 0", v, 0);
      wr(2'd3, 32'h1234);
      rd(2'd1, v); check("R5 pop ignored", v, 0);
    end

    // length mismatch
    wr(2'd2, pword(3, 0)); wr(2'd2, 32'd5); wr(2'd2, 32'd9);
    wr(2'd0, 32'h2);
    rd(2'd1, v); check("R6 mismatch error", v, 32'h2);
    check("R6 no response", hrsp_valid, 0);
    // start while error
    wr(2'd0, 32'h2);
    rd(2'd1, v); check("R10 start ignored", v, 32'h2);
    wr(2'd0, 32'h1);
    rd(2'd1, v); check("R9 abort clears", v, 0);

    // zero length field means 2^18
    wr(2'd2, pword(0, 0)); wr(2'd2, 32'h0);
    wr(2'd0, 32'h2);
    rd(2'd1, v); check("R6 zero length mismatch", v, 32'h2);
    // start while error with a now-valid object
    send_obj(1);
    wr(2'd0, 32'h2);
    rd(2'd1, v); check("R10 valid object ignored", v, 32'h2);
    check("R10 handler idle", hreq_valid, 0);
    wr(2'd0, 32'h1);

    // abort flushes partial request
    wr(2'd2, 32'h1); wr(2'd2, 32'h2); wr(2'd2, 32'h3);
    wr(2'd0, 32'h1);
    send_obj(1);
    wr(2'd0, 32'h2);
    wait_idle();
    rd(2'd1, v); check("R9 flushed request", v, 32'h4);
    rd(2'd3, v); check("R9 fresh head", v, pword(1, 0));
    wr(2'd0, 32'h1);
    rd(2'd1, v); check("R9 abort drops response", v, 0);
    rd(2'd3, v); check("R9 rdata zero", v, 0);

    // overflow of request FIFO
    for (int i = 0; i < DEPTH; i++) wr(2'd2, i);
    rd(2'd1, v); check("R7 full no error", v, 0);
    wr(2'd2, 32'hFF);
    rd(2'd1, v); check("R7 overflow error", v, 32'h2);
    wr(2'd0, 32'h1);

    // write data and start while busy
    hold = 1;
    send_obj(2);
    wr(2'd0, 32'h2);
    repeat (8) @(negedge clk);
    rd(2'd1, v); check("R3 busy held", v, 32'h1);
    wr(2'd2, 32'h77);
    rd(2'd1, v); check("R8 data while busy", v, 32'h3);
    wr(2'd0, 32'h2);
    rd(2'd1, v); check("R8 start while busy", v, 32'h3);
    hold = 0;
    wait_idle();
    rd(2'd1, v); check("R3 done keeps error", v, 32'h6);
    rd(2'd3, v); check("R8 response intact", v, pword(2, 0));
    wr(2'd0, 32'h1);

    // response overflow
    extra = 2;
    send_obj(DEPTH - 2);
    wr(2'd0, 32'h2);
    wait_idle();
    rd(2'd1, v); check("R11 overflow error", v, 32'h6);
    for (int i = 0; i < DEPTH; i++) begin
      rd(2'd3, v); check("R11 stored dwords", v, pword(DEPTH - 2, i));
      wr(2'd3, 0);
    end
    rd(2'd1, v); check("R11 drained", v[2], 0);
    extra = 0;
    wr(2'd0, 32'h1);
    rd(2'd1, v); check("R9 final abort", v, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule